// File: doc/BRIEF.md
# Three-Phase Gate-Drive Fault Supervisor

This block sits between the six PWM commands of a three-phase bridge and the six gate-enable outputs that control the bridge's drivers. Each phase has one command for the high side and one for the low side. A gate output follows its command only while the chip enable input is high and no protection fault is latched. If either condition fails, all six gates are forced low.

Two protections watch the drivers, and each applies only while its own driver is commanded on:
- **Undervoltage.** A per-driver undervoltage flag becomes a fault only after it stays asserted for longer than a programmable debounce count.
- **Short circuit.** A per-MOSFET drain-source over-threshold flag becomes a fault only after a programmable blanking interval has passed since the gate turned on.

The first fault latches. It drives an active-low fault pin and fills a status word that names the driver and the fault kind. The latch clears only on reset or when chip enable is dropped.

A small configuration register, loaded through a valid/data write port, holds these fields:
- the two detector enables;
- a 2-bit short-circuit threshold code, passed on to the external comparator;
- the debounce count;
- the blanking count.

The comparator flags and the PWM commands arrive asynchronously, so they pass through two-flop synchronizers first.

Top module: `gate_fault_supervisor`

## Requirements
- R1: All six gate outputs are 0 whenever `chip_en` is 0 or a fault is latched, regardless of the PWM inputs.
- R2: With `chip_en`=1 and no fault latched, each gate output equals its PWM input delayed by the two-flop synchronizer: a PWM change driven in cycle k shows at the gate in cycle k+2. Driver index i = 2*phase + side, where side 0 is high and side 1 is low. The flag vectors use the same index.
- R3: An undervoltage flag counts only while its driver's gate is on. It becomes a fault only when it is seen for more than `dbnc` consecutive synchronized cycles. A shorter pulse, or a pulse on a driver that is off, leaves all outputs unchanged.
- R4: A drain-source flag on a driver whose gate is on (after blanking) latches a fault and turns all gates off in the next cycle. A flag on a driver that is off is ignored.
- R5: A latched fault persists after its cause goes away. It clears in the cycle after `chip_en` is sampled low, or on reset.
- R6: A drain-source flag is ignored during the first `blank` cycles after a gate turns on. With the flag present from turn-on, the fault shows at the outputs `blank`+1 cycles after the gate does.
- R7: `fault_n` is 0 exactly while a fault is latched. Sub-debounce undervoltage events never pull it low.
- R8: A write with `cfg_wr_valid`=1 loads `cfg_wr_data` in the next cycle. The field layout is [0]=undervoltage enable, [1]=short-circuit enable, [3:2]=threshold code, [11:4]=`dbnc`, [19:12]=`blank`. Threshold codes are 00=250 mV, 01=500 mV, 10=750 mV, 11=1000 mV, and `sc_thr_sel` outputs the stored code. After reset, both detectors are enabled, the threshold code is 00, `dbnc`=3 and `blank`=2.
- R9: The status word is {valid, short-circuit, undervoltage, phase[1:0], side}. It records the first fault only. On simultaneous hits, the lowest driver index wins, and both kind bits are set if that driver hit both ways. It reads 0 when no fault is latched.
- R10: A detector whose enable bit is 0 never sets a fault, even with its flags held asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable; low forces gates off and clears faults |
| pwm_hi | input | 3 | High-side gate commands, one per phase |
| pwm_lo | input | 3 | Low-side gate commands, one per phase |
| uv_flag | input | 6 | Per-driver undervoltage flags, index 2*phase+side |
| ds_flag | input | 6 | Per-driver drain-source over-threshold flags, same index |
| cfg_wr_valid | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 20 | Configuration word |
| gate_hi | output | 3 | High-side gate enables |
| gate_lo | output | 3 | Low-side gate enables |
| sc_thr_sel | output | 2 | Short-circuit threshold code to the comparator |
| fault_n | output | 1 | Active-low latched-fault indicator |
| status | output | 6 | First-fault record |

## Verification
Two things can land in the same clock edge:
- an undervoltage debounce expiring and a short-circuit blanking window closing;
- hits on two different drivers at once.

The bench provokes the first case by setting `dbnc` equal to `blank` and raising both flags together with the gate command on one driver. It provokes the second with `dbnc`=0 and a fully settled bridge, flagging driver 5 for undervoltage and driver 3 for short circuit in the same cycle. Each case is judged on the status word in the cycle the fault appears: both kind bits are expected in the first case, and driver 3 alone in the second.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
    localparam int unsigned N_PH  = 3;
    localparam int unsigned N_DRV = 2 * N_PH;
    localparam int unsigned IDX_W = $clog2(N_DRV);
    localparam int unsigned PH_W  = $clog2(N_PH);
    localparam int unsigned CNT_W = 8;
    localparam int unsigned THR_W = 2;
    localparam int unsigned CFG_W = 2 + THR_W + 2 * CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] blank;
        logic [CNT_W-1:0] dbnc;
        logic [THR_W-1:0] thr;
        logic             sc_en;
        logic             uv_en;
    } cfg_t;

    typedef struct packed {
        logic            valid;
        logic            kind_sc;
        logic            kind_uv;
        logic [PH_W-1:0] phase;
        logic            side;
    } status_t;

    localparam int unsigned ST_W = $bits(status_t);
endpackage

// File: rtl/gfs_sync.sv
module gfs_sync #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = din;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.s2;
endmodule

// File: rtl/gfs_cfg.sv
module gfs_cfg
    import gfs_pkg::*;
#(
    parameter cfg_t RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_valid) cfg_d = cfg_t'(wr_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= RST_VAL;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    assert_cfg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (cfg_q == cfg_t'($past(wr_data))));
endmodule

// File: rtl/gfs_chan.sv
module gfs_chan
    import gfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on,
    input  logic             uv_s,
    input  logic             ds_s,
    input  logic             uv_en,
    input  logic             sc_en,
    input  logic [CNT_W-1:0] dbnc,
    input  logic [CNT_W-1:0] blank,
    output logic             uv_hit,
    output logic             sc_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] on_cnt;
        logic [CNT_W-1:0] uv_cnt;
    } chan_t;

    chan_t st_d, st_q;
    logic  uv_live;

    always_comb begin
        st_d    = st_q;
        uv_live = on && uv_en && uv_s;

        // cycles elapsed since gate turn-on, saturating at the blanking limit
        if (!on)                    st_d.on_cnt = '0;
        else if (st_q.on_cnt < blank) st_d.on_cnt = st_q.on_cnt + 1'b1;

        // consecutive qualified undervoltage cycles, saturating at debounce limit
        if (!uv_live)                st_d.uv_cnt = '0;
        else if (st_q.uv_cnt < dbnc) st_d.uv_cnt = st_q.uv_cnt + 1'b1;

        uv_hit = uv_live && (st_q.uv_cnt >= dbnc);
        sc_hit = on && sc_en && ds_s && (st_q.on_cnt >= blank);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_uv_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> (st_q.uv_cnt == '0));

    assert_blank_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (on && !$past(on) && (blank != '0)) |-> !sc_hit);
endmodule

// File: rtl/gate_fault_supervisor.sv
module gate_fault_supervisor
    import gfs_pkg::*;
#(
    parameter int unsigned DBNC_RST  = 3,
    parameter int unsigned BLANK_RST = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chip_en,
    input  logic [N_PH-1:0]  pwm_hi,
    input  logic [N_PH-1:0]  pwm_lo,
    input  logic [N_DRV-1:0] uv_flag,
    input  logic [N_DRV-1:0] ds_flag,
    input  logic             cfg_wr_valid,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [N_PH-1:0]  gate_hi,
    output logic [N_PH-1:0]  gate_lo,
    output logic [THR_W-1:0] sc_thr_sel,
    output logic             fault_n,
    output logic [ST_W-1:0]  status
);
    localparam cfg_t CFG_RST = '{
        blank: CNT_W'(BLANK_RST),
        dbnc:  CNT_W'(DBNC_RST),
        thr:   '0,
        sc_en: 1'b1,
        uv_en: 1'b1
    };

    typedef struct packed {
        logic    fault;
        status_t stat;
    } sup_t;

    sup_t st_d, st_q;
    cfg_t cfg;

    logic [N_DRV-1:0] pwm_raw, pwm_s, uv_s, ds_s;
    logic [N_DRV-1:0] gate, uv_hit, sc_hit;
    logic             any_hit;
    logic [IDX_W-1:0] win_idx;

    // pack commands as index 2*phase+side (side 0 = high)
    for (genvar p = 0; p < N_PH; p++) begin : g_pack
        assign pwm_raw[2*p]     = pwm_hi[p];
        assign pwm_raw[2*p + 1] = pwm_lo[p];
        assign gate_hi[p]       = gate[2*p];
        assign gate_lo[p]       = gate[2*p + 1];
    end

    gfs_sync #(.W(3 * N_DRV)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ds_flag, uv_flag, pwm_raw}),
        .dout  ({ds_s, uv_s, pwm_s})
    );

    gfs_cfg #(.RST_VAL(CFG_RST)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (cfg_wr_valid),
        .wr_data  (cfg_wr_data),
        .cfg      (cfg)
    );

    assign gate = pwm_s & {N_DRV{chip_en && !st_q.fault}};

    for (genvar i = 0; i < N_DRV; i++) begin : g_chan
        gfs_chan i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .on     (gate[i]),
            .uv_s   (uv_s[i]),
            .ds_s   (ds_s[i]),
            .uv_en  (cfg.uv_en),
            .sc_en  (cfg.sc_en),
            .dbnc   (cfg.dbnc),
            .blank  (cfg.blank),
            .uv_hit (uv_hit[i]),
            .sc_hit (sc_hit[i])
        );
    end

    always_comb begin
        st_d    = st_q;
        any_hit = |(uv_hit | sc_hit);
        win_idx = '0;
        // lowest index with a hit wins
        for (int i = N_DRV - 1; i >= 0; i--) begin
            if (uv_hit[i] || sc_hit[i]) win_idx = IDX_W'(i);
        end

        if (!chip_en) begin
            st_d = '0;
        end else if (!st_q.fault && any_hit) begin
            st_d.fault        = 1'b1;
            st_d.stat.valid   = 1'b1;
            st_d.stat.kind_sc = sc_hit[win_idx];
            st_d.stat.kind_uv = uv_hit[win_idx];
            st_d.stat.phase   = PH_W'(win_idx >> 1);
            st_d.stat.side    = win_idx[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_n    = !st_q.fault;
    assign status     = st_q.stat;
    assign sc_thr_sel = cfg.thr;

    assert_gates_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |-> (gate_hi == '0 && gate_lo == '0));

    assert_fault_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.fault) |-> $past(any_hit));

    assert_fault_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fault && chip_en) |=> st_q.fault);

    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fault && chip_en) |=> $stable(st_q.stat));
endmodule

// File: tb/test_gate_fault_supervisor.sv
module test_gate_fault_supervisor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chip_en = 1'b0;
    logic [2:0]  pwm_hi = '0, pwm_lo = '0;
    logic [5:0]  uv_flag = '0, ds_flag = '0;
    logic        cfg_wr_valid = 1'b0;
    logic [19:0] cfg_wr_data = '0;
    logic [2:0]  gate_hi, gate_lo;
    logic [1:0]  sc_thr_sel;
    logic        fault_n;
    logic [5:0]  status;

    int cyc = 0, n_run = 0, n_fail = 0;
    logic [1:0] cur_thr = 2'b00;
    logic done = 1'b0;

    typedef struct {
        int         due;
        logic [5:0] gate;
        logic       fn;
        logic [5:0] st;
        logic [1:0] thr;
        string      tag;
    } item_t;
    item_t sb[$];

    gate_fault_supervisor i_gate_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .uv_flag(uv_flag), .ds_flag(ds_flag),
        .cfg_wr_valid(cfg_wr_valid), .cfg_wr_data(cfg_wr_data),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .sc_thr_sel(sc_thr_sel),
        .fault_n(fault_n), .status(status)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // driver side: index 2*phase+side
    task automatic set_pwm(input logic [5:0] v);
        for (int p = 0; p < 3; p++) begin
            pwm_hi[p] = v[2*p];
            pwm_lo[p] = v[2*p + 1];
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int dly, input logic [5:0] g, input logic fn,
                             input logic [5:0] st, input string tag);
        item_t it;
        it.due = cyc + dly; it.gate = g; it.fn = fn; it.st = st;
        it.thr = cur_thr; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr_cfg(input logic uv, input logic sc, input logic [1:0] thr,
                          input logic [7:0] db, input logic [7:0] bl);
        cfg_wr_valid = 1'b1;
        cfg_wr_data  = {bl, db, thr, sc, uv};
        step(1);
        cfg_wr_valid = 1'b0;
        cur_thr = thr;
    endtask

    task automatic clear_fault();
        uv_flag = '0; ds_flag = '0; set_pwm('0);
        chip_en = 1'b0;
        expect_at(1, 6'h00, 1'b1, 6'h00, "R5 clear on enable low");
        step(2);
        chip_en = 1'b1;
        step(3);
    endtask

    // monitor: compare expected items in their cycle, away from the edge
    always @(negedge clk) begin
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [5:0] g;
                for (int p = 0; p < 3; p++) begin
                    g[2*p] = gate_hi[p];
                    g[2*p + 1] = gate_lo[p];
                end
                n_run++;
                if (g !== sb[i].gate || fault_n !== sb[i].fn ||
                    status !== sb[i].st || sc_thr_sel !== sb[i].thr) begin
                    n_fail++;
                    $display("FAIL %s @%0d: got gate=%h fn=%b st=%b thr=%b, expected gate=%h fn=%b st=%b thr=%b",
                             sb[i].tag, cyc, g, fault_n, status, sc_thr_sel,
                             sb[i].gate, sb[i].fn, sb[i].st, sb[i].thr);
                end
                sb.delete(i);
            end
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        expect_at(0, 6'h00, 1'b1, 6'h00, "R8 reset state");
        step(1);

        // R1: disabled chip keeps gates low
        set_pwm(6'h3F);
        expect_at(3, 6'h00, 1'b1, 6'h00, "R1 gates low with enable off");
        step(4);

        // R2: follow commands with sync latency
        chip_en = 1'b1;
        expect_at(0, 6'h3F, 1'b1, 6'h00, "R2 enable passes commands");
        step(1);
        set_pwm(6'b100110);
        expect_at(1, 6'h3F, 1'b1, 6'h00, "R2 old value one cycle in");
        expect_at(2, 6'b100110, 1'b1, 6'h00, "R2 pattern A");
        step(3);
        set_pwm(6'b011001);
        expect_at(2, 6'b011001, 1'b1, 6'h00, "R2 pattern B");
        step(3);

        // R8: configuration write and threshold output
        wr_cfg(1'b1, 1'b1, 2'b10, 8'd3, 8'd2);
        expect_at(0, 6'b011001, 1'b1, 6'h00, "R8 threshold code loaded");
        step(1);

        // R3/R7: short undervoltage on an on driver is ignored
        set_pwm(6'h3F);
        step(3);
        uv_flag[0] = 1'b1;
        expect_at(9, 6'h3F, 1'b1, 6'h00, "R7 sub-debounce no fault");
        step(3);
        uv_flag[0] = 1'b0;
        step(7);

        // R3: undervoltage on an off driver is ignored
        set_pwm(6'h3D);
        step(3);
        uv_flag[1] = 1'b1;
        expect_at(12, 6'h3D, 1'b1, 6'h00, "R3 off driver undervoltage ignored");
        step(12);
        uv_flag[1] = 1'b0;
        step(3);

        // R3/R9/R1: sustained undervoltage on driver 4 (phase 2 high)
        set_pwm(6'h3F);
        step(3);
        uv_flag[4] = 1'b1;
        expect_at(5, 6'h3F, 1'b1, 6'h00, "R3 no fault before debounce");
        expect_at(6, 6'h00, 1'b0, 6'b101100, "R3 undervoltage fault latched");
        step(8);
        uv_flag[4] = 1'b0;
        expect_at(5, 6'h00, 1'b0, 6'b101100, "R5 fault sticks after cause");
        step(6);
        chip_en = 1'b0;
        expect_at(0, 6'h00, 1'b0, 6'b101100, "R1 enable low still latched");
        expect_at(1, 6'h00, 1'b1, 6'h00, "R5 cleared by enable low");
        step(2);
        chip_en = 1'b1;
        expect_at(0, 6'h3F, 1'b1, 6'h00, "R5 drives again after re-enable");
        step(3);

        // R6: drain-source flag inside blanking window ignored
        set_pwm(6'h00);
        step(3);
        set_pwm(6'h08); ds_flag[3] = 1'b1;
        expect_at(2, 6'h08, 1'b1, 6'h00, "R2 driver 3 on");
        expect_at(6, 6'h08, 1'b1, 6'h00, "R6 flag in blanking ignored");
        step(2);
        ds_flag[3] = 1'b0;
        step(6);

        // R4/R6: flag held past blanking trips
        set_pwm(6'h00);
        step(3);
        set_pwm(6'h08); ds_flag[3] = 1'b1;
        expect_at(4, 6'h08, 1'b1, 6'h00, "R6 last blanked cycle");
        expect_at(5, 6'h00, 1'b0, 6'b110011, "R4 short-circuit fault");
        step(7);
        clear_fault();

        // R4: flag on an off driver ignored
        set_pwm(6'h01);
        step(3);
        ds_flag[5] = 1'b1;
        expect_at(10, 6'h01, 1'b1, 6'h00, "R4 off driver flag ignored");
        step(10);
        ds_flag[5] = 1'b0;
        step(3);

        // R10: both detectors disabled
        wr_cfg(1'b0, 1'b0, 2'b01, 8'd2, 8'd2);
        set_pwm(6'h3F);
        step(3);
        uv_flag = 6'h3F; ds_flag = 6'h3F;
        expect_at(12, 6'h3F, 1'b1, 6'h00, "R10 disabled detectors silent");
        step(12);
        uv_flag = '0; ds_flag = '0;
        step(3);

        // R9: both kinds on one driver in the same cycle
        wr_cfg(1'b1, 1'b1, 2'b11, 8'd2, 8'd2);
        set_pwm(6'h00);
        expect_at(3, 6'h00, 1'b1, 6'h00, "R8 threshold code 11");
        step(3);
        set_pwm(6'h04); uv_flag[2] = 1'b1; ds_flag[2] = 1'b1;
        expect_at(4, 6'h04, 1'b1, 6'h00, "R9 before joint hit");
        expect_at(5, 6'h00, 1'b0, 6'b111010, "R9 both kinds same driver");
        step(7);
        clear_fault();

        // R9: two drivers hit in the same cycle, lowest index reported
        wr_cfg(1'b1, 1'b1, 2'b11, 8'd0, 8'd2);
        set_pwm(6'h3F);
        step(5);
        uv_flag[5] = 1'b1; ds_flag[3] = 1'b1;
        expect_at(2, 6'h3F, 1'b1, 6'h00, "R9 before simultaneous hits");
        expect_at(3, 6'h00, 1'b0, 6'b110011, "R9 lowest index wins");
        step(6);
        clear_fault();

        step(2);
        if (sb.size() != 0) begin
            n_fail += sb.size();
            n_run  += sb.size();
            $display("FAIL scoreboard: %0d expectations never checked, expected 0", sb.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule